// File: doc/BRIEF.md
# Serial ADC Conversion-and-Read Controller

This block is the host-side master for a self-timed 12-bit serial converter that sits behind a three-wire port: chip select, serial clock and one data line. A one-cycle `start_i` pulse drops chip select with the serial clock held low. The converter then runs its conversion on its own internal clock while the serial clock stays idle. Once the conversion has finished, the controller produces thirteen serial clock periods in mode 0 (idle low, sample on the rising edge) and then raises chip select.

The end of conversion can be detected in two ways, chosen per transaction by `tmo_mode_i`. In line mode the controller waits for the data line to go from low to high. In timeout mode it simply waits a fixed number of system cycles. The first bit captured is the converter's end-of-conversion marker and is stripped. The remaining twelve bits, MSB first, are presented on `data_o` with a one-cycle `valid_o` strobe. In timeout mode a marker that reads 0 raises `frame_err_o` together with the result.

The serial clock phase width and the minimum chip-select-high gap are enforced in system-clock cycles. The gap covers both the required deselect time and the converter's re-acquisition time. `busy_o` covers the whole transaction, including that gap. `abort_i` ends a transaction early and still applies the gap.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset `cs_no` is 1, `sclk_o` is 0, and `busy_o` and `valid_o` are 0. A `start_i` pulse while idle drives `cs_no` to 0 with `sclk_o` still 0. `sclk_o` is 0 in every cycle where `cs_no` is 1.
- R2: With `tmo_mode_i`=0 at start, `sclk_o` stays 0 until the synchronised data input has been seen low and then high after chip select fell. The first rising edge of `sclk_o` comes HALF_CYC cycles after that detection.
- R3: With `tmo_mode_i`=1 at start, the first rising edge of `sclk_o` comes CONV_CYC+HALF_CYC cycles after `cs_no` falls, whatever the data line does.
- R4: A completed read has exactly RES_W+1 (13) rising and 13 falling edges of `sclk_o` while `cs_no` is 0. `cs_no` rises on the 13th falling edge.
- R5: Data is sampled on each rising edge of `sclk_o`. The first sample is dropped, and the next 12 form `data_o` with the first of them in bit 11. `valid_o` is high for exactly one cycle, the cycle in which `cs_no` has just risen. `data_o` holds its value until the next completed read.
- R6: Every high phase and every low phase of `sclk_o` lasts at least HALF_CYC system cycles.
- R7: Once `cs_no` rises, it stays high for at least GAP_CYC cycles before it can fall again. `busy_o` stays 1 from the start pulse until exactly GAP_CYC cycles after `cs_no` rose.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: no extra read follows, and `cs_no` stays high once the gap has ended.
- R9: `abort_i` during conversion or shifting raises `cs_no` and forces `sclk_o` to 0 on the next cycle. No `valid_o` follows, `data_o` keeps its value, and the GAP_CYC gap is still enforced.
- R10: On each completed read, `frame_err_o` is set to 1 when the read was in timeout mode and the dropped first sample was 0; otherwise it is set to 0. It never sets in line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a conversion and read |
| abort_i | input | 1 | Ends the current transaction early |
| tmo_mode_i | input | 1 | 0: data-line end of conversion, 1: fixed timeout (latched at start) |
| sdi_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| busy_o | output | 1 | Transaction or re-acquisition gap in progress |
| valid_o | output | 1 | One-cycle strobe for a new result |
| data_o | output | RES_W | Last completed result, MSB first on the wire |
| frame_err_o | output | 1 | Marker bit read as 0 in timeout mode |

## Verification
A small converter model in the bench answers chip select and the serial clock. It returns codes drawn at random, plus the all-zero, all-one, single-MSB and single-LSB codes. Together these show whether bit order, marker stripping and shifting are right. The conversion times are random. In line mode some of them exceed the timeout, so the measured start-to-first-clock latency shows which end-of-conversion path was taken. A converter slower than the timeout checks the framing flag, and a following normal read checks that the flag clears. Directed cases cover aborts during conversion and during shifting, and a start issued while busy. In each of these the bench checks that chip select stays high and that the stored result is untouched.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int HALF_CYC = 10,   // system cycles per serial clock phase
  parameter int CONV_CYC = 850,  // end-of-conversion timeout
  parameter int GAP_CYC  = 150   // chip select high / re-acquisition
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tmo_mode_i,
  input  logic             sdi_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] data_o,
  output logic             frame_err_o
);
  localparam int NCLK  = RES_W + 1;
  localparam int MAX_A = (CONV_CYC > GAP_CYC) ? CONV_CYC : GAP_CYC;
  localparam int MAXC  = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = $clog2(NCLK + 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_B  = BIT_W'(NCLK);

  rd_state_e        st_q, st_d;
  logic             cs_q, cs_d, sclk_q, sclk_d, mode_q, mode_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             valid_q, err_q;
  logic [RES_W-1:0] data_q;
  logic             sdi_s, prev_q, sdi_rise;
  logic             tmr_load, tmr_zero, cap_en, done;
  logic [CNT_W-1:0] tmr_val;
  logic [NCLK-1:0]  frame;

  adc_rd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s)
  );

  adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  adc_rd_capture #(.W(NCLK)) u_cap (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(cap_en), .bit_i(sdi_s), .word_o(frame)
  );

  // edge detector is re-armed high outside conversion: a line held high
  // by a pull-up must first be seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= (st_q == ST_CONV) ? sdi_s : 1'b1;
  end
  assign sdi_rise = sdi_s & ~prev_q;

  always_comb begin
    st_d     = st_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    bit_d    = bit_q;
    mode_d   = mode_q;
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    cap_en   = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_CONV;
          cs_d     = 1'b0;
          mode_d   = tmo_mode_i;
          tmr_load = 1'b1;
          tmr_val  = CONV_LD;
        end
      end
      ST_CONV: begin
        if (abort_i) begin
          st_d     = ST_GAP;
          cs_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end else if (mode_q ? tmr_zero : sdi_rise) begin
          st_d     = ST_SHIFT;
          bit_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end
      end
      ST_SHIFT: begin
        if (abort_i) begin
          st_d     = ST_GAP;
          cs_d     = 1'b1;
          sclk_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end else if (tmr_zero) begin
          tmr_load = 1'b1;
          if (!sclk_q) begin
            sclk_d  = 1'b1;
            cap_en  = 1'b1;
            bit_d   = bit_q + 1'b1;
            tmr_val = HALF_LD;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == LAST_B) begin
              st_d    = ST_GAP;
              cs_d    = 1'b1;
              done    = 1'b1;
              tmr_val = GAP_LD;
            end else begin
              tmr_val = HALF_LD;
            end
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      bit_q   <= '0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      bit_q   <= bit_d;
      mode_q  <= mode_d;
      valid_q <= done;
      if (done) begin
        data_q <= frame[RES_W-1:0];
        err_q  <= mode_q & ~frame[RES_W];
      end
    end
  end

  assign cs_no       = cs_q;
  assign sclk_o      = sclk_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign valid_o     = valid_q;
  assign data_o      = data_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk #(
  parameter int RES_W    = 12,
  parameter int HALF_CYC = 10,
  parameter int GAP_CYC  = 150
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic abort_i,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o
);
  localparam int NCLK = RES_W + 1;

  logic        sclk_d, cs_d;
  int unsigned sclk_run, cs_run, fall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      sclk_run <= HALF_CYC;
      cs_run   <= GAP_CYC;
      fall_cnt <= 0;
    end else begin
      sclk_d <= sclk_o;
      cs_d   <= cs_no;
      if (sclk_o != sclk_d)        sclk_run <= 1;
      else if (sclk_run < HALF_CYC) sclk_run <= sclk_run + 1;
      if (cs_no != cs_d)           cs_run <= 1;
      else if (cs_run < GAP_CYC)   cs_run <= cs_run + 1;
      if (cs_no)                   fall_cnt <= 0;
      else if (sclk_d && !sclk_o)  fall_cnt <= fall_cnt + 1;
    end
  end

  // R1
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R1
  select_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_d && !cs_no) |-> !sclk_o);
  // R4
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((fall_cnt + 32'(sclk_d & ~sclk_o)) == NCLK));
  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R5
  valid_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (busy_o && cs_no && cs_d == 1'b0));
  // R6
  phase_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_d) |-> (sclk_run >= HALF_CYC));
  // R7
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_d && !cs_no) |-> (cs_run >= GAP_CYC));
  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && cs_no) |=> cs_no);
  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o && !cs_no) |=> (cs_no && !sclk_o && !valid_o));
endmodule

bind adc_read_ctrl adc_read_ctrl_chk #(
  .RES_W(RES_W), .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)
) chk_i (.*);

// File: tb/adc_read_ctrl_tb_top.sv
module adc_read_ctrl_tb_top;
  localparam int RES_W    = 12;
  localparam int HALF_CYC = 10;
  localparam int CONV_CYC = 850;
  localparam int GAP_CYC  = 150;
  localparam int NCLK     = RES_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, tmo_mode = 1'b0;
  logic adc_sdo = 1'b1;
  logic cs_no, sclk, busy, valid, ferr;
  logic [RES_W-1:0] data;

  always #5 clk = ~clk;

  adc_read_ctrl #(
    .RES_W(RES_W), .HALF_CYC(HALF_CYC), .CONV_CYC(CONV_CYC), .GAP_CYC(GAP_CYC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .tmo_mode_i(tmo_mode), .sdi_i(adc_sdo), .cs_no(cs_no), .sclk_o(sclk),
    .busy_o(busy), .valid_o(valid), .data_o(data), .frame_err_o(ferr)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // converter model inputs
  logic [RES_W-1:0] code_m = '0;
  int               ctime_m = 100;

  // monitor results
  int valid_cnt = 0, rises = 0, first_lat = 0, min_ph = 1000000, last_gap = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int lat_lo(input bit mode, input int ctime);
    return mode ? CONV_CYC + HALF_CYC : ctime + HALF_CYC;
  endfunction
  function automatic int lat_hi(input bit mode, input int ctime);
    return mode ? CONV_CYC + HALF_CYC + 2 : ctime + HALF_CYC + 6;
  endfunction

  // converter model: pull-up while deselected, low during conversion,
  // marker then MSB-first data shifted on falling serial clock
  initial begin
    logic [NCLK-1:0] sh = '0;
    int  left = 0;
    bit  cs_prev = 1, sclk_prev = 0;
    forever begin
      @(negedge clk);
      if (cs_no) begin
        adc_sdo = 1'b1;
        left    = 0;
        cs_prev = 1;
      end else begin
        if (cs_prev) begin
          left    = ctime_m;
          adc_sdo = 1'b0;
          sh      = {1'b1, code_m};
        end else if (left > 0) begin
          left--;
          if (left == 0) adc_sdo = sh[NCLK-1];
        end else if (sclk_prev && !sclk) begin
          sh      = {sh[NCLK-2:0], 1'b0};
          adc_sdo = sh[NCLK-1];
        end
        cs_prev = 0;
      end
      sclk_prev = sclk;
    end
  end

  // port monitor
  initial begin
    bit cs_p = 1, sclk_p = 0, busy_p = 0, got = 0;
    int lat = 0, ph = 0, gap = 0;
    forever begin
      @(negedge clk);
      if (valid) valid_cnt++;
      if (!cs_no) begin
        if (cs_p) begin lat = 0; rises = 0; got = 0; end
        if (sclk && !sclk_p) begin
          rises++;
          if (!got) begin first_lat = lat; got = 1; end
        end
        if (!got) lat++;
        gap = 0;
      end else if (busy) gap++;
      if (sclk != sclk_p) begin
        if (ph < min_ph) min_ph = ph;
        ph = 1;
      end else ph++;
      if (busy_p && !busy) last_gap = gap;
      cs_p = cs_no; sclk_p = sclk; busy_p = busy;
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_txn(input logic [RES_W-1:0] code, input int ctime, input bit mode,
                         input bit dup, input bit exp_err);
    int v0;
    code_m = code; ctime_m = ctime;
    @(negedge clk);
    v0 = valid_cnt;
    tmo_mode = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0; tmo_mode = ~mode;  // latched at start
    chk(!cs_no && !sclk, "R1 select with clock low", int'(cs_no), 0);
    if (dup) begin
      repeat (60) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_idle();
    chk(valid_cnt - v0 == 1, "R5 one strobe per read", valid_cnt - v0, 1);
    chk(rises == NCLK, "R4 serial clock count", rises, NCLK);
    chk(first_lat >= lat_lo(mode, ctime) && first_lat <= lat_hi(mode, ctime),
        mode ? "R3 timeout latency" : "R2 line latency", first_lat, lat_lo(mode, ctime));
    chk(last_gap >= GAP_CYC, "R7 gap before idle", last_gap, GAP_CYC);
    chk(ferr == exp_err, "R10 framing flag", int'(ferr), int'(exp_err));
    if (!exp_err) chk(data == code, "R5 result", int'(data), int'(code));
    if (dup) begin
      repeat (100) @(negedge clk);
      chk(cs_no && !busy && valid_cnt - v0 == 1, "R8 start while busy ignored",
          valid_cnt - v0, 1);
    end
  endtask

  task automatic run_abort(input int wait_cyc, input int ctime);
    int v0;
    logic [RES_W-1:0] keep;
    keep = data; code_m = ~data; ctime_m = ctime;
    @(negedge clk);
    v0 = valid_cnt;
    tmo_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (wait_cyc) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(cs_no && !sclk, "R9 abort deselects", int'(cs_no), 1);
    wait_idle();
    chk(valid_cnt == v0, "R9 no strobe on abort", valid_cnt - v0, 0);
    chk(data == keep, "R9 result kept", int'(data), int'(keep));
    chk(last_gap >= GAP_CYC, "R9 gap after abort", last_gap, GAP_CYC);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_no && !sclk && !busy && !valid, "R1 reset state",
        {28'd0, cs_no, sclk, busy, valid}, 8);

    // directed corner codes
    run_txn(12'h000, 120, 1'b0, 1'b0, 1'b0);
    run_txn(12'hFFF, 400, 1'b1, 1'b0, 1'b0);
    run_txn(12'h800, 300, 1'b0, 1'b0, 1'b0);
    run_txn(12'h001, 600, 1'b1, 1'b0, 1'b0);
    // line mode with conversion longer than the timeout
    run_txn(12'hA5C, 1000, 1'b0, 1'b0, 1'b0);
    // converter slower than timeout, then flag clears
    run_txn(12'h3C3, 1000, 1'b1, 1'b0, 1'b1);
    run_txn(12'h3C3, 200, 1'b1, 1'b0, 1'b0);
    // start while busy
    run_txn(12'h5A5, 250, 1'b0, 1'b1, 1'b0);
    // abort during conversion and during shifting
    run_abort(100, 500);
    run_abort(170, 100);

    for (int i = 0; i < 16; i++) begin
      logic [RES_W-1:0] c;
      bit m;
      int t;
      c = RES_W'($urandom % 4096);
      m = 1'($urandom % 2);
      t = m ? 100 + int'($urandom % 700) : 50 + int'($urandom % 900);
      run_txn(c, t, m, 1'b0, 1'b0);
    end

    chk(min_ph >= HALF_CYC, "R6 minimum clock phase", min_ph, HALF_CYC);
    finish_run();
  end
endmodule